// File: doc/BRIEF.md
# Multiplexed-Bus Register File with Detect Interrupt

This block is the processor-facing register interface of a modem data pump. A host drives an 8-bit multiplexed address/data bus. It presents an address together with a chip-select level and drops an address strobe to capture them. It then completes a read or a write with active-low strobes. The block holds two read/write control words and a read/write tone word, and exposes all three to the core. It also holds a read-only detect word whose bits are set by event inputs from the detectors.

Any set detect bit pulls an active-low interrupt line. The host finds out which detector fired by reading the detect word. That read clears the bits it returned. An event that lands in the same cycle as the clear is kept.

The strobes come from an asynchronous host. Each one passes through a two-flop synchronizer, and the block acts on edges of the synchronized copies. The bus is split into an input, an output and an output enable, so the pad ring can form the tri-state driver. Every port is plain control or status, so no valid/ready handshake applies here.

Top module: `mux_bus_regfile`

## Requirements
- R1: A falling edge of `ale` captures `bus_in[2:0]` as the register address and the level of `cs_n` as the latched select. Both keep their values until the next falling edge of `ale`, whatever the bus carries in between.
- R2: `bus_oe` is 1 only while `rd_n` is low and the latched select is low. While `bus_oe` is 1, `bus_out` carries the addressed register. At all other times `bus_oe` is 0 and `bus_out` is 0.
- R3: A rising edge of `wr_n` writes `bus_in` into the addressed register, but only when the latched select is low. With the latched select high, no register changes.
- R4: The address map is: 0 is control word 0, 1 is control word 1, 2 is the detect word and 3 is the tone word. Addresses 0, 1 and 3 read back what was last written to them.
- R5: A write to address 2 leaves the detect word unchanged.
- R6: Addresses 4 to 7 read as 8'h00, and writes to them change no register.
- R7: Detect bit i is set on a rising edge of `evt_in[i]`. It stays set when the input falls, until a detect read clears it.
- R8: A detect read returns the value of the detect word at the moment `rd_n` falls. When `rd_n` rises, exactly the returned set bits are cleared. A bit whose event rises in the clearing cycle stays set.
- R9: `irq_n` is 0 whenever any detect bit is set, and 1 when none is set.
- R10: Reset (active high) clears both control words, the tone word and the detect word, and sets `irq_n` to 1.
- R11: `xmit_en` equals bit 1 of control word 0.
- R12: A strobe edge takes effect at most 3 clock cycles after it reaches the pin. The address and select must stay stable for 4 cycles after `ale` falls. Write data must stay stable for 4 cycles after `wr_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address strobe; its falling edge captures address and select |
| cs_n | input | 1 | Chip select, active low; captured with the address |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; data is committed on its rising edge |
| bus_in | input | 8 | Address/data bus as seen at the pad input |
| bus_out | output | 8 | Read data for the pad driver |
| bus_oe | output | 1 | Pad driver enable; 0 means the bus floats |
| evt_in | input | 8 | Detector event lines, one per detect bit |
| ctrl0_q | output | 8 | Control word 0 |
| ctrl1_q | output | 8 | Control word 1 |
| tone_q | output | 8 | Tone word |
| xmit_en | output | 1 | Transmit enable, bit 1 of control word 0 |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A wrong address latch or a wrong select latch appears on the very next strobed access. Data then goes to, or comes from, the wrong word, or `bus_oe` rises when it should stay low. This shows within three cycles of the strobe edge. A detect word that is not sticky, or that clears too much, shows first on `irq_n` and then on a second detect read. The event that races the clear is the sharpest case: a design that drops it shows `irq_n` high immediately after the read completes.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL0 = 3'd0,
    A_CTRL1 = 3'd1,
    A_DET   = 3'd2,
    A_TONE  = 3'd3
  } reg_addr_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= RST_VAL;
      s2 <= RST_VAL;
      s3 <= RST_VAL;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign level = s2;
  assign rise  = s2 & ~s3;
  assign fall  = ~s2 & s3;

  // R12: an edge of the synchronized copy is reported as one pulse only
  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    (rise | fall) != '0 |=> ((rise & $past(rise)) | (fall & $past(fall))) == '0);
endmodule

// File: rtl/bus_front.sv
module bus_front #(
  parameter int ADDR_W = mbr_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale_fall,
  input  logic [ADDR_W-1:0] addr_pins,
  input  logic              cs_n_pin,
  input  logic              rd_lvl_n,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              lat_cs_n,
  output logic              drive_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_addr <= '0;
      lat_cs_n <= 1'b1;
    end else if (ale_fall) begin
      lat_addr <= addr_pins;
      lat_cs_n <= cs_n_pin;
    end
  end

  assign drive_en = ~rd_lvl_n & ~lat_cs_n;

  // R1: the latched pair changes only on a synchronized ale fall
  assert_latch_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !ale_fall |=> $stable(lat_addr) && $stable(lat_cs_n));
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import mbr_pkg::*;
#(
  parameter int DATA_W = mbr_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_rise,
  input  logic              lat_cs_n,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl0,
  output logic [DATA_W-1:0] ctrl1,
  output logic [DATA_W-1:0] tone
);
  logic commit;
  assign commit = wr_rise & ~lat_cs_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl0 <= '0;
      ctrl1 <= '0;
      tone  <= '0;
    end else if (commit) begin
      case (lat_addr)
        A_CTRL0: ctrl0 <= wdata;
        A_CTRL1: ctrl1 <= wdata;
        A_TONE:  tone  <= wdata;
        default: ;
      endcase
    end
  end

  // R3: no committed write means no register change
  assert_no_write_without_cs_R3: assert property (@(posedge clk) disable iff (rst)
    !(wr_rise && !lat_cs_n) |=> $stable(ctrl0) && $stable(ctrl1) && $stable(tone));

  // R6: writes to the upper addresses are dropped
  assert_high_addr_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    lat_addr[ADDR_W-1] |=> $stable(ctrl0) && $stable(ctrl1) && $stable(tone));
endmodule

// File: rtl/detect_flags.sv
module detect_flags #(
  parameter int DATA_W = mbr_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt_in,
  input  logic              rd_start,
  input  logic              rd_end_strobe,
  output logic [DATA_W-1:0] det,
  output logic [DATA_W-1:0] snap
);
  logic [DATA_W-1:0] evt_q, evt_rise, clr_mask;
  logic              armed, rd_end;

  assign evt_rise = evt_in & ~evt_q;
  assign rd_end   = rd_end_strobe & armed;
  assign clr_mask = rd_end ? snap : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      det   <= '0;
      snap  <= '0;
      armed <= 1'b0;
    end else begin
      evt_q <= evt_in;
      det   <= (det & ~clr_mask) | evt_rise;
      if (rd_start) begin
        snap  <= det;
        armed <= 1'b1;
      end else if (rd_end) begin
        armed <= 1'b0;
      end
    end
  end

  // R7: bits only drop when a detect read completes
  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_end |=> (det & $past(det)) == $past(det));

  // R8: a completed read leaves none of the returned bits set unless re-raised
  assert_clear_returned_R8: assert property (@(posedge clk) disable iff (rst)
    rd_end |=> (det & $past(snap) & ~$past(evt_rise)) == '0);
endmodule

// File: rtl/mux_bus_regfile.sv
module mux_bus_regfile
  import mbr_pkg::*;
#(
  parameter int DW = mbr_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ale,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [DW-1:0] evt_in,
  output logic [DW-1:0] ctrl0_q,
  output logic [DW-1:0] ctrl1_q,
  output logic [DW-1:0] tone_q,
  output logic          xmit_en,
  output logic          irq_n
);
  localparam int SEL_ALE = 2;
  localparam int SEL_RD  = 1;
  localparam int SEL_WR  = 0;

  logic [2:0]        st_lvl, st_rise, st_fall;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_cs_n, det_sel;
  logic [DW-1:0]     det, snap, rd_mux;

  strobe_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst(rst), .async_in({ale, rd_n, wr_n}),
    .level(st_lvl), .rise(st_rise), .fall(st_fall)
  );

  bus_front #(.ADDR_W(ADDR_W)) u_front (
    .clk(clk), .rst(rst), .ale_fall(st_fall[SEL_ALE]),
    .addr_pins(bus_in[ADDR_W-1:0]), .cs_n_pin(cs_n),
    .rd_lvl_n(st_lvl[SEL_RD]), .lat_addr(lat_addr),
    .lat_cs_n(lat_cs_n), .drive_en(bus_oe)
  );

  reg_bank #(.DATA_W(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_rise(st_rise[SEL_WR]),
    .lat_cs_n(lat_cs_n), .lat_addr(lat_addr), .wdata(bus_in),
    .ctrl0(ctrl0_q), .ctrl1(ctrl1_q), .tone(tone_q)
  );

  assign det_sel = (lat_addr == A_DET) & ~lat_cs_n;

  detect_flags #(.DATA_W(DW)) u_det (
    .clk(clk), .rst(rst), .evt_in(evt_in),
    .rd_start(st_fall[SEL_RD] & det_sel),
    .rd_end_strobe(st_rise[SEL_RD]),
    .det(det), .snap(snap)
  );

  always_comb begin
    case (lat_addr)
      A_CTRL0: rd_mux = ctrl0_q;
      A_CTRL1: rd_mux = ctrl1_q;
      A_DET:   rd_mux = snap;
      A_TONE:  rd_mux = tone_q;
      default: rd_mux = '0;
    endcase
  end

  assign bus_out = bus_oe ? rd_mux : '0;
  assign xmit_en = ctrl0_q[1];
  assign irq_n   = ~(|det);

  // R2: the driver is only enabled two cycles after a low read strobe
  assert_oe_needs_read_R2: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $past(rd_n, 2) == 1'b0);

  // R6: upper addresses never return data
  assert_high_addr_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && lat_addr[ADDR_W-1]) |-> bus_out == '0);

  // R9: a fresh event pulls the interrupt on the following cycle
  assert_event_raises_irq_R9: assert property (@(posedge clk) disable iff (rst)
    (evt_in & ~$past(evt_in)) != '0 |=> !irq_n);
endmodule

// File: tb/tb_mux_bus_regfile.sv
module tb_mux_bus_regfile;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] bus_in = 8'h00, evt_in = 8'h00;
  logic [7:0] bus_out, ctrl0_q, ctrl1_q, tone_q;
  logic       bus_oe, xmit_en, irq_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mux_bus_regfile dut (
    .clk(clk), .rst(rst), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .evt_in(evt_in),
    .ctrl0_q(ctrl0_q), .ctrl1_q(ctrl1_q), .tone_q(tone_q),
    .xmit_en(xmit_en), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latch(input logic [2:0] a, input logic sel_n);
    ale = 1'b1; cs_n = sel_n; bus_in = {5'b10101, a};
    wait_n(4);
    ale = 1'b0;
    wait_n(5);
    bus_in = 8'hFF; cs_n = ~sel_n;
  endtask

  task automatic bwrite(input logic [7:0] d);
    bus_in = d; wr_n = 1'b0;
    wait_n(5);
    wr_n = 1'b1;
    wait_n(5);
    bus_in = 8'hFF;
  endtask

  task automatic bread(output logic [7:0] d, output logic oe);
    rd_n = 1'b0;
    wait_n(5);
    d = bus_out; oe = bus_oe;
    rd_n = 1'b1;
    wait_n(5);
  endtask

  task automatic pulse_evt(input logic [7:0] m);
    evt_in = m; wait_n(2); evt_in = 8'h00; wait_n(2);
  endtask

  task automatic t_reset;
    logic [7:0] d; logic oe;
    chk("R10 ctrl0 after reset", ctrl0_q, 8'h00);
    chk("R10 irq after reset", {7'b0, irq_n}, 8'h01);
    chk("R2 bus idle oe", {7'b0, bus_oe}, 8'h00);
    latch(3'd0, 1'b0); bwrite(8'h5A);
    latch(3'd3, 1'b0); bwrite(8'hC3);
    pulse_evt(8'h10);
    rst = 1'b1; wait_n(3); rst = 1'b0; wait_n(2);
    chk("R10 ctrl0 cleared", ctrl0_q, 8'h00);
    chk("R10 tone cleared", tone_q, 8'h00);
    chk("R10 irq released", {7'b0, irq_n}, 8'h01);
    latch(3'd2, 1'b0); bread(d, oe);
    chk("R10 detect cleared", d, 8'h00);
  endtask

  task automatic t_rw;
    logic [7:0] d; logic oe;
    latch(3'd0, 1'b0); bwrite(8'hA6);
    latch(3'd1, 1'b0); bwrite(8'h3C);
    latch(3'd3, 1'b0); bwrite(8'h81);
    chk("R4 ctrl0 port", ctrl0_q, 8'hA6);
    chk("R4 ctrl1 port", ctrl1_q, 8'h3C);
    chk("R4 tone port", tone_q, 8'h81);
    chk("R11 xmit_en set", {7'b0, xmit_en}, 8'h01);
    latch(3'd1, 1'b0); bread(d, oe);
    chk("R4 ctrl1 readback", d, 8'h3C);
    chk("R2 oe during read", {7'b0, oe}, 8'h01);
    chk("R2 oe after read", {7'b0, bus_oe}, 8'h00);
    latch(3'd0, 1'b0); bread(d, oe);
    chk("R4 ctrl0 readback", d, 8'hA6);
    latch(3'd3, 1'b0); bread(d, oe);
    chk("R1 R4 tone readback with bus changed", d, 8'h81);
    latch(3'd0, 1'b0); bwrite(8'hA4);
    chk("R11 xmit_en clear", {7'b0, xmit_en}, 8'h00);
  endtask

  task automatic t_cs_inactive;
    logic [7:0] d; logic oe;
    latch(3'd1, 1'b1); bwrite(8'hEE);
    chk("R3 no write when deselected", ctrl1_q, 8'h3C);
    bread(d, oe);
    chk("R2 no drive when deselected", {7'b0, oe}, 8'h00);
    chk("R2 bus_out zero when deselected", d, 8'h00);
  endtask

  task automatic t_high_addr;
    logic [7:0] d; logic oe;
    latch(3'd5, 1'b0); bwrite(8'h77);
    chk("R6 ctrl0 untouched", ctrl0_q, 8'hA4);
    chk("R6 ctrl1 untouched", ctrl1_q, 8'h3C);
    chk("R6 tone untouched", tone_q, 8'h81);
    bread(d, oe);
    chk("R6 high addr reads zero", d, 8'h00);
    chk("R6 high addr still driven", {7'b0, oe}, 8'h01);
  endtask

  task automatic t_detect;
    logic [7:0] d; logic oe;
    pulse_evt(8'h05);
    chk("R9 irq on event", {7'b0, irq_n}, 8'h00);
    latch(3'd2, 1'b0); bwrite(8'h00);
    bread(d, oe);
    chk("R5 R7 detect sticky, write ignored", d, 8'h05);
    chk("R8 R9 irq released after read", {7'b0, irq_n}, 8'h01);
    bread(d, oe);
    chk("R8 detect cleared by read", d, 8'h00);
    pulse_evt(8'h40);
    evt_in = 8'h02; wait_n(1);
    rd_n = 1'b0; wait_n(5);
    d = bus_out;
    chk("R8 read returns both bits", d, 8'h42);
    rd_n = 1'b1;
    wait_n(5);
    chk("R7 held input does not re-set", {7'b0, irq_n}, 8'h01);
    evt_in = 8'h00; wait_n(2);
  endtask

  task automatic t_same_cycle;
    logic [7:0] d; logic oe;
    pulse_evt(8'h01);
    latch(3'd2, 1'b0);
    rd_n = 1'b0; wait_n(5);
    chk("R8 snapshot", bus_out, 8'h01);
    rd_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    evt_in = 8'h01;
    wait_n(2);
    evt_in = 8'h00;
    wait_n(3);
    chk("R8 R9 racing event keeps irq", {7'b0, irq_n}, 8'h00);
    bread(d, oe);
    chk("R8 racing event kept", d, 8'h01);
    chk("R9 irq high after final read", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_sync_latency;
    latch(3'd1, 1'b0);
    bus_in = 8'h99; wr_n = 1'b0; wait_n(4);
    wr_n = 1'b1; wait_n(2);
    chk("R12 not yet committed at 2 cycles", ctrl1_q, 8'h3C);
    wait_n(2);
    chk("R12 committed within 3 cycles", ctrl1_q, 8'h99);
  endtask

  initial begin
    fork
      begin
        wait_n(4); rst = 1'b0; wait_n(2);
        t_reset();
        t_rw();
        t_cs_inactive();
        t_high_addr();
        t_detect();
        t_same_cycle();
        t_sync_latency();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule